// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the receive half of an Ethernet MAC's data mover. Frame bytes arrive one per cycle on a byte stream, which marks the last byte and carries the error flags for the frame. The engine places the bytes in memory buffers that software describes through a ring of two-word descriptors. Each descriptor holds a status/control word at its own address and a buffer address word four bytes above it. The engine reads the current descriptor. If software has handed it over, the engine packs the frame into 32-bit words and writes them to the buffer. It then writes the status word back with the stored length and the error flags, and with the hand-over bit cleared, so that software polling the word sees the frame complete.

There is no fixed ring size. A wrap bit in each descriptor sends the engine back to the ring base; otherwise it steps to the next descriptor, eight bytes further on. When the engine reads a descriptor that software has not handed over, it drops its own run bit and stays idle until software sets it again. Frames that arrive while no descriptor is held are consumed and discarded. Memory is reached through a simple word master: the request is held until acknowledged, and read data comes with the acknowledge.

Top module: `rxdma_top`

## Requirements
- R1: After reset `rx_on` and `mem_req` are low and `in_ready` is high, so incoming bytes are consumed and discarded.
- R2: A one-cycle pulse on `rx_go` sets `rx_on`. The engine then reads the status word at the current pointer, followed by the buffer address word at pointer+4.
- R3: If the fetched status word has bit 11 (hand-over) clear, `rx_on` goes low on the next cycle and nothing is written. Frames that arrive afterwards are discarded until `rx_go` is pulsed again.
- R4: Stored bytes go to consecutive words starting at the buffer address with bits 1:0 forced to zero. Byte k of a word sits in bits 8k+7:8k. In the final partial word, the unused upper lanes are zero.
- R5: The write-back status word holds the stored byte count in bits 10:0 and 0 in bit 11. Bit 12 copies the fetched wrap bit and bit 13 is the too-long flag. Bits 14, 15 and 16 carry the alignment, overrun and CRC flags, taken from `in_err[1]`, `in_err[2]` and `in_err[0]` on the last byte. All other bits are zero.
- R6: At most BUF_BYTES (1540) bytes are stored per frame. Later bytes are discarded and set the too-long flag. A frame of exactly BUF_BYTES bytes does not set the flag.
- R7: After a write-back, the pointer moves to `ring_base` when the wrap bit was set and to pointer+8 otherwise. The next descriptor is then fetched at once if `rx_on` is high.
- R8: A pulse on `base_wr` loads the descriptor pointer from `ring_base`.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until `mem_ack`. Every address is word aligned.
- R10: `in_ready` is low in every cycle in which `mem_req` is high.
- R11: A frame whose first byte arrives while no descriptor is held is discarded up to its last byte, even if `rx_go` is pulsed in the middle of it. The next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of the first descriptor |
| base_wr | input | 1 | Load the descriptor pointer from ring_base |
| rx_go | input | 1 | Set the receive run bit |
| rx_on | output | 1 | Receive run bit |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 3 | Frame errors with the last byte: [0] CRC, [1] alignment, [2] overrun |
| in_ready | output | 1 | Byte is taken this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes |

## Verification
Two events can coincide. One is the arrival of a frame's last byte. The other is the buffer reaching its limit, which forces a truncation decision on that same byte. The bench sends a frame one byte longer than the buffer, so the last byte is the first one to be discarded. It then sends a frame of exactly the buffer size, where the limit and the end of frame fall on the same stored byte. The stored length, the too-long flag and the absence of any write past the buffer are compared against a queue of expected memory writes built from the requirements.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int LEN_W       = 11;
  localparam int EN_BIT      = 11;
  localparam int WRAP_BIT    = 12;
  localparam int TOOLONG_BIT = 13;
  localparam int ALIGN_BIT   = 14;
  localparam int OVR_BIT     = 15;
  localparam int CRC_BIT     = 16;
  localparam logic [31:0] DESC_STRIDE = 32'd8;

  typedef enum logic [2:0] {
    ST_OFF, ST_DROP, ST_RD_STAT, ST_RD_ADDR, ST_RECV, ST_WR_DATA, ST_WR_STAT
  } rx_state_e;

  // matches in_err ordering: [2] overrun, [1] alignment, [0] crc
  typedef struct packed {
    logic ovr;
    logic align;
    logic crc;
  } rx_err_t;

  function automatic logic [31:0] wb_word(input logic [LEN_W-1:0] len,
                                          input logic wrap,
                                          input logic too_long,
                                          input rx_err_t e);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0]  = len;
    w[WRAP_BIT]    = wrap;
    w[TOOLONG_BIT] = too_long;
    w[ALIGN_BIT]   = e.align;
    w[OVR_BIT]     = e.ovr;
    w[CRC_BIT]     = e.crc;
    return w;
  endfunction

  function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic wrap);
    return wrap ? base : cur + DESC_STRIDE;
  endfunction
endpackage

// File: rtl/rxdma_pack.sv
module rxdma_pack #(
  parameter int BUF_BYTES = 1540,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             drain,
  output logic             store,
  output logic [31:0]      word,
  output logic [2:0]       lanes,
  output logic [CNT_W-1:0] cnt,
  output logic             trunc
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BUF_BYTES);

  logic [7:0] lane_q [4];

  assign store = push && (cnt < CAP);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       lane_q[g] <= '0;
      else if (clear || drain)          lane_q[g] <= '0;
      else if (store && lanes == 3'(g)) lane_q[g] <= din;
    end
  end

  assign word = {lane_q[3], lane_q[2], lane_q[1], lane_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes <= '0;
      cnt   <= '0;
      trunc <= 1'b0;
    end else if (clear) begin
      lanes <= '0;
      cnt   <= '0;
      trunc <= 1'b0;
    end else begin
      if (drain)          lanes <= '0;
      else if (store)     lanes <= lanes + 3'd1;
      if (store)          cnt   <= cnt + 1'b1;
      if (push && !store) trunc <= 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] base,
  input  logic        step,
  input  logic        wrap,
  output logic [31:0] cur
);
  import rxdma_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= base;
    else if (step) cur <= next_desc(cur, base, wrap);
  end
endmodule

// File: rtl/rxdma_top.sv
module rxdma_top #(
  parameter int BUF_BYTES = 1540
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        base_wr,
  input  logic        rx_go,
  output logic        rx_on,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [2:0]  in_err,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  import rxdma_pkg::*;

  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int LW    = LEN_W;

  rx_state_e        state, state_n;
  logic [31:0]      cur, buf_q, ofs_q;
  logic             wrap_q, eof_q;
  rx_err_t          err_q;
  logic             take, store, trunc;
  logic [31:0]      word;
  logic [2:0]       lanes, lanes_after;
  logic [CNT_W-1:0] byte_cnt;

  // named events used by the bound checker
  logic fetch_stop, fetch_ok, addr_done, word_done, wb_done;

  assign take       = in_valid && in_ready;
  assign fetch_stop = (state == ST_RD_STAT) && mem_ack && !mem_rdata[EN_BIT];
  assign fetch_ok   = (state == ST_RD_STAT) && mem_ack &&  mem_rdata[EN_BIT];
  assign addr_done  = (state == ST_RD_ADDR) && mem_ack;
  assign word_done  = (state == ST_WR_DATA) && mem_ack;
  assign wb_done    = (state == ST_WR_STAT) && mem_ack;

  rxdma_pack #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(addr_done),
    .push(take && state == ST_RECV), .din(in_data), .drain(word_done),
    .store(store), .word(word), .lanes(lanes), .cnt(byte_cnt), .trunc(trunc)
  );

  rxdma_ring u_ring (
    .clk(clk), .rst_n(rst_n), .load(base_wr), .base(ring_base),
    .step(wb_done), .wrap(wrap_q), .cur(cur)
  );

  assign lanes_after = lanes + {2'b00, store};

  always_comb begin
    state_n = state;
    unique case (state)
      ST_OFF:     if (take && !in_last) state_n = ST_DROP;
                  else if (rx_on)       state_n = ST_RD_STAT;
      ST_DROP:    if (take && in_last)  state_n = ST_OFF;
      ST_RD_STAT: if (fetch_stop)       state_n = ST_OFF;
                  else if (fetch_ok)    state_n = ST_RD_ADDR;
      ST_RD_ADDR: if (addr_done)        state_n = ST_RECV;
      ST_RECV:    if (take) begin
                    if (in_last)
                      state_n = (lanes_after != 3'd0) ? ST_WR_DATA : ST_WR_STAT;
                    else if (lanes_after == 3'd4)
                      state_n = ST_WR_DATA;
                  end
      ST_WR_DATA: if (word_done)        state_n = eof_q ? ST_WR_STAT : ST_RECV;
      ST_WR_STAT: if (wb_done)          state_n = ST_OFF;
      default:                          state_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_OFF;
      rx_on  <= 1'b0;
      buf_q  <= '0;
      ofs_q  <= '0;
      wrap_q <= 1'b0;
      eof_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      state <= state_n;
      if (rx_go)           rx_on <= 1'b1;
      else if (fetch_stop) rx_on <= 1'b0;
      if (fetch_ok) wrap_q <= mem_rdata[WRAP_BIT];
      if (addr_done) begin
        buf_q <= mem_rdata & ~32'd3;
        ofs_q <= '0;
        eof_q <= 1'b0;
        err_q <= '0;
      end
      if (state == ST_RECV && take && in_last) begin
        eof_q <= 1'b1;
        err_q <= rx_err_t'(in_err);
      end
      if (word_done) ofs_q <= ofs_q + 32'd4;
    end
  end

  always_comb begin
    in_ready  = (state == ST_OFF) || (state == ST_DROP) || (state == ST_RECV);
    mem_req   = (state == ST_RD_STAT) || (state == ST_RD_ADDR) ||
                (state == ST_WR_DATA) || (state == ST_WR_STAT);
    mem_we    = (state == ST_WR_DATA) || (state == ST_WR_STAT);
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_RD_STAT: mem_addr = cur;
      ST_RD_ADDR: mem_addr = cur + 32'd4;
      ST_WR_DATA: begin
        mem_addr  = buf_q + ofs_q;
        mem_wdata = word;
      end
      ST_WR_STAT: begin
        mem_addr  = cur;
        mem_wdata = wb_word(LW'(byte_cnt), wrap_q, trunc, err_q);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk #(
  parameter int BUF_BYTES = 1540,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             in_ready,
  input logic             rx_on,
  input logic             rx_go,
  input logic             fetch_stop,
  input logic             wb_done,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             trunc
);
  import rxdma_pkg::*;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R10
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  // R3
  stop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stop && !rx_go |=> !rx_on);

  // R5
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |-> mem_we && !mem_wdata[EN_BIT]);

  // R6
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(BUF_BYTES));

  // R6
  trunc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done && trunc |-> mem_wdata[LEN_W-1:0] == LEN_W'(BUF_BYTES) && mem_wdata[TOOLONG_BIT]);
endmodule

bind rxdma_top rxdma_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .in_ready(in_ready), .rx_on(rx_on),
  .rx_go(rx_go), .fetch_stop(fetch_stop), .wb_done(wb_done), .byte_cnt(byte_cnt),
  .trunc(trunc)
);

// File: tb/rxdma_top_test.sv
module rxdma_top_test;
  localparam int BUF = 1540;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = '0;
  logic        base_wr = 1'b0, rx_go = 1'b0, rx_on;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic [2:0]  in_err = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  string       exp_tag  [$];
  string       idle_tag = "R11";

  logic [31:0] m_cur = '0, m_base = '0;
  bit          m_on = 1'b0;

  always #4 clk = ~clk;

  rxdma_top #(.BUF_BYTES(BUF)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .base_wr(base_wr), .rx_go(rx_go),
    .rx_on(rx_on), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory slave and per-clock comparison against the expected write queue
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      check("R9 word aligned address", {30'b0, mem_addr[1:0]}, 32'h0);
      check("R10 ready low during access", {31'b0, in_ready}, 32'h0);
    end
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (exp_addr.size() == 0) begin
          check({idle_tag, " unexpected write address"}, mem_addr, 32'hFFFF_FFFF);
        end else begin
          check({exp_tag[0], " write address"}, mem_addr, exp_addr[0]);
          check({exp_tag[0], " write data"}, mem_wdata, exp_data[0]);
          void'(exp_addr.pop_front());
          void'(exp_data.pop_front());
          void'(exp_tag.pop_front());
        end
      end else begin
        mem_rdata = rd(mem_addr);
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 7) & 8'hFF);
  endfunction

  task automatic settle(input string tag);
    repeat (40) @(negedge clk);
    m_on = m_on && rd(m_cur)[11];
    check({tag, " pending writes"}, 32'(exp_addr.size()), 32'h0);
    check({tag, " run bit"}, {31'b0, rx_on}, {31'b0, m_on});
  endtask

  task automatic send_frame(input int len, input int seed, input logic [2:0] err,
                            input int go_at, input string tag);
    if (m_on) begin
      logic [31:0] st, ba, w, sw;
      int stored;
      st = rd(m_cur);
      ba = rd(m_cur + 32'd4) & ~32'd3;
      stored = (len > BUF) ? BUF : len;
      for (int wi = 0; wi * 4 < stored; wi++) begin
        w = '0;
        for (int k = 0; k < 4; k++)
          if (wi * 4 + k < stored) w[8*k +: 8] = pat(seed, wi * 4 + k);
        exp_addr.push_back(ba + 32'(wi * 4));
        exp_data.push_back(w);
        exp_tag.push_back({tag, " R4 data"});
      end
      sw = 32'(stored) | (32'(st[12]) << 12) | (32'(len > BUF) << 13) |
           (32'(err[1]) << 14) | (32'(err[2]) << 15) | (32'(err[0]) << 16);
      exp_addr.push_back(m_cur);
      exp_data.push_back(sw);
      exp_tag.push_back({tag, " R5 status"});
      m_cur = st[12] ? m_base : m_cur + 32'd8;
    end
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = pat(seed, i);
      in_last  = (i == len - 1);
      in_err   = (i == len - 1) ? err : 3'b000;
      rx_go    = (i == go_at);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      rx_go = 1'b0;
      if (i == go_at) m_on = 1'b1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_err   = '0;
    settle(tag);
  endtask

  task automatic go(input string tag);
    @(negedge clk) rx_go = 1'b1;
    @(negedge clk) rx_go = 1'b0;
    m_on = 1'b1;
    settle(tag);
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk);
    ring_base = b;
    base_wr   = 1'b1;
    @(negedge clk) base_wr = 1'b0;
    m_cur  = b;
    m_base = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // descriptors: status (bit 11 hand-over, bit 12 wrap), then buffer address
    mem[32'h100] = 32'h0000_0800; mem[32'h104] = 32'h0000_1000;
    mem[32'h108] = 32'h0000_0800; mem[32'h10C] = 32'h0000_1802;
    mem[32'h110] = 32'h0000_1800; mem[32'h114] = 32'h0000_2400;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_on after reset", {31'b0, rx_on}, 32'h0);
    check("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
    check("R1 in_ready after reset", {31'b0, in_ready}, 32'h1);

    // R8 pointer load, R1/R11 frame discarded while off
    load_base(32'h100);
    idle_tag = "R1";
    send_frame(5, 3, 3'b000, -1, "R1 frame while off");

    // R2 start receiving
    idle_tag = "R2";
    go("R2 start");
    send_frame(7, 10, 3'b000, -1, "R4 short frame");
    // R6 one byte over the buffer, last byte is the first dropped
    send_frame(BUF + 1, 40, 3'b001, -1, "R6 overlong frame");
    // R6 exactly full, R5 flags, R7 wrap to base which is now released -> R3 stop
    idle_tag = "R3";
    send_frame(BUF, 77, 3'b110, -1, "R6 full frame R7 wrap R3 stop");
    send_frame(3, 5, 3'b000, -1, "R3 frame while stopped");

    // R7 refill the base descriptor: next frame lands at the base again
    mem[32'h100] = 32'h0000_0800;
    idle_tag = "R7";
    go("R7 restart");
    send_frame(4, 90, 3'b000, -1, "R7 frame at ring base");

    // R11 rx_go in the middle of a discarded frame
    mem[32'h108] = 32'h0000_0800;
    idle_tag = "R11";
    send_frame(6, 20, 3'b000, 2, "R11 discarded frame");
    send_frame(2, 60, 3'b100, -1, "R11 next frame");

    // R8 move the ring to a new base with a single self-wrapping descriptor
    mem[32'h200] = 32'h0000_1800; mem[32'h204] = 32'h0000_3000;
    idle_tag = "R8";
    load_base(32'h200);
    go("R8 restart");
    send_frame(9, 33, 3'b010, -1, "R8 frame at new base");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule